// File: doc/BRIEF.md
# Timer Slot Busy-Map Scanner

This block is a hardware helper for a software timing wheel. The host keeps every timer queue in its own memory. The scanner keeps only one busy bit for each slot of the wheel and a slot pointer. The pointer moves forward by one slot on each tick.

When the pointer lands on a slot whose bit is set, the scanner raises an interrupt and presents that slot number. Idle slots are stepped over silently, so the host is only disturbed on ticks that have real work.

The host marks a slot busy when a timer enters an empty queue. It marks the slot idle when the last timer leaves that queue. The number of slots in use is written at start-up, up to a build-time maximum.

An interrupt stays up until the host acknowledges it. Busy slots reached while an interrupt is still up wait in a short queue. If that queue is full, the slot is lost and a sticky overflow flag is raised.

Top module: `slot_busy_scanner`

## Requirements
- R1: After reset, irq and ovf are low, the pointer is at slot 0, every slot is idle, and the wheel size equals MAX_SLOTS.
- R2: A cfg_we pulse with cfg_size in 1..MAX_SLOTS sets the wheel size. It also moves the pointer to slot 0, drops the pending interrupt and the queued slots, and clears ovf. Busy bits are kept. A cfg_we pulse with cfg_size of 0 or above MAX_SLOTS changes nothing.
- R3: Each cycle with tick high moves the pointer to the next slot. From slot size-1 it moves to slot 0.
- R4: If the slot reached by a tick is busy, irq is high from the next cycle with irq_slot equal to that slot. A tick that reaches an idle slot raises no interrupt.
- R5: irq and irq_slot hold their values until a cycle with irq_ack high. After an acknowledge with nothing queued, irq is low in the next cycle.
- R6: Busy slots reached while irq is high are queued, up to FIFO_DEPTH of them. Each acknowledge presents the oldest queued slot in the next cycle.
- R7: A busy slot reached while irq is high and the queue is full is dropped and sets ovf. ovf stays high until reset or an accepted configuration write.
- R8: set_en marks set_slot busy and clr_en marks clr_slot idle, both from the next cycle. If both target the same slot in the same cycle, the slot ends up idle.
- R9: A set or clear whose slot number is at or above the current wheel size has no effect.
- R10: A busy slot stays busy until it is cleared, so it raises an interrupt on every lap of the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the wheel size |
| cfg_size | input | SIZE_W | Wheel size to write (1..MAX_SLOTS) |
| tick | input | 1 | Timer tick; advances the pointer |
| set_en | input | 1 | Mark a slot busy |
| set_slot | input | SLOT_W | Slot to mark busy |
| clr_en | input | 1 | Mark a slot idle |
| clr_slot | input | SLOT_W | Slot to mark idle |
| irq_ack | input | 1 | Host acknowledge of the current interrupt |
| irq | output | 1 | Interrupt: a busy slot was reached |
| irq_slot | output | SLOT_W | Slot number carried by the interrupt |
| ovf | output | 1 | Sticky flag: a reached busy slot was lost |

## Verification
The bench builds the scanner with MAX_SLOTS = 16 and FIFO_DEPTH = 2. A 16-slot wheel lets a full lap from reset at the default size finish in a few cycles. Small configured sizes of 3 to 8 slots make wraparound and repeated laps quick to reach.

A two-entry queue can be filled with four adjacent busy slots. This drives the overflow path and the in-order draining. Shrinking and regrowing the wheel shows that sets and clears beyond the size are ignored.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Where a busy slot reached by a tick is sent
    typedef enum logic [1:0] {
        ROUTE_NONE   = 2'd0,
        ROUTE_DIRECT = 2'd1,
        ROUTE_QUEUE  = 2'd2,
        ROUTE_DROP   = 2'd3
    } hit_route_e;

endpackage

// File: rtl/sbs_busy_map.sv
module sbs_busy_map #(
    parameter int MAX_SLOTS = 64,
    parameter int SLOT_W    = 6,
    parameter int SIZE_W    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SIZE_W-1:0]    size,
    input  logic                 set_en,
    input  logic [SLOT_W-1:0]    set_slot,
    input  logic                 clr_en,
    input  logic [SLOT_W-1:0]    clr_slot,
    output logic [MAX_SLOTS-1:0] busy
);

    typedef struct packed {
        logic [MAX_SLOTS-1:0] bits;
    } map_st_t;

    map_st_t st_d, st_q;

    logic set_in_range, clr_in_range;

    always_comb begin
        set_in_range = SIZE_W'(set_slot) < size;
        clr_in_range = SIZE_W'(clr_slot) < size;
        st_d = st_q;
        if (set_en && set_in_range) begin
            st_d.bits[set_slot] = 1'b1;
        end
        // Clear is applied last so it wins over a set to the same slot
        if (clr_en && clr_in_range) begin
            st_d.bits[clr_slot] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.bits;

endmodule

// File: rtl/sbs_slot_fifo.sv
module sbs_slot_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    logic do_pop, do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = din;
                st_d.wr           = ptr_inc(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = ptr_inc(st_q.rd);
            end
            if (do_push && !do_pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/slot_busy_scanner.sv
module slot_busy_scanner
    import sbs_pkg::*;
#(
    parameter int  MAX_SLOTS  = 64,
    parameter int  FIFO_DEPTH = 4,
    localparam int SLOT_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int SIZE_W     = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              tick,
    input  logic              set_en,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic              irq_ack,
    output logic              irq,
    output logic [SLOT_W-1:0] irq_slot,
    output logic              ovf
);

    typedef struct packed {
        logic [SLOT_W-1:0] ptr;
        logic [SIZE_W-1:0] size;
        logic              irq;
        logic [SLOT_W-1:0] irq_slot;
        logic              ovf;
    } scan_st_t;

    localparam scan_st_t RESET_ST = '{
        ptr:      '0,
        size:     SIZE_W'(MAX_SLOTS),
        irq:      1'b0,
        irq_slot: '0,
        ovf:      1'b0
    };

    scan_st_t st_d, st_q;

    logic [MAX_SLOTS-1:0] busy;
    logic [SLOT_W-1:0]    ptr_next;
    logic [SLOT_W-1:0]    fifo_dout;
    logic                 fifo_empty, fifo_full;
    logic                 fifo_push, fifo_pop;
    logic                 cfg_ok, hit, releasing;
    hit_route_e           route;
    logic [SLOT_W-1:0]    cur_ptr;
    logic [SIZE_W-1:0]    cur_size;

    sbs_busy_map #(
        .MAX_SLOTS (MAX_SLOTS),
        .SLOT_W    (SLOT_W),
        .SIZE_W    (SIZE_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .size     (st_q.size),
        .set_en   (set_en),
        .set_slot (set_slot),
        .clr_en   (clr_en),
        .clr_slot (clr_slot),
        .busy     (busy)
    );

    sbs_slot_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SLOT_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cfg_ok),
        .push  (fifo_push),
        .din   (ptr_next),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        cfg_ok    = cfg_we && (cfg_size != '0) && (cfg_size <= SIZE_W'(MAX_SLOTS));
        ptr_next  = (SIZE_W'(st_q.ptr) == st_q.size - SIZE_W'(1)) ? '0 : st_q.ptr + 1'b1;
        hit       = tick && busy[ptr_next] && !cfg_ok;
        releasing = st_q.irq && irq_ack && !cfg_ok;
        fifo_pop  = releasing && !fifo_empty;

        // Route the reached busy slot
        route = ROUTE_NONE;
        if (hit) begin
            if (!st_q.irq || (releasing && fifo_empty)) begin
                route = ROUTE_DIRECT;
            end else if (!fifo_full || fifo_pop) begin
                route = ROUTE_QUEUE;
            end else begin
                route = ROUTE_DROP;
            end
        end
        fifo_push = (route == ROUTE_QUEUE);

        st_d = st_q;
        if (cfg_ok) begin
            st_d.size     = cfg_size;
            st_d.ptr      = '0;
            st_d.irq      = 1'b0;
            st_d.irq_slot = '0;
            st_d.ovf      = 1'b0;
        end else begin
            if (tick) begin
                st_d.ptr = ptr_next;
            end
            if (releasing) begin
                if (!fifo_empty) begin
                    st_d.irq_slot = fifo_dout;
                end else begin
                    st_d.irq = 1'b0;
                end
            end
            case (route)
                ROUTE_DIRECT: begin
                    st_d.irq      = 1'b1;
                    st_d.irq_slot = ptr_next;
                end
                ROUTE_DROP:   st_d.ovf = 1'b1;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq      = st_q.irq;
    assign irq_slot = st_q.irq_slot;
    assign ovf      = st_q.ovf;
    assign cur_ptr  = st_q.ptr;
    assign cur_size = st_q.size;

endmodule

// File: rtl/slot_busy_scanner_chk.sv
module slot_busy_scanner_chk #(
    parameter int  MAX_SLOTS = 64,
    localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int SIZE_W    = $clog2(MAX_SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              tick,
    input logic              irq_ack,
    input logic              irq,
    input logic [SLOT_W-1:0] irq_slot,
    input logic              ovf,
    input logic [SLOT_W-1:0] cur_ptr,
    input logic [SIZE_W-1:0] cur_size
);

    a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_size != '0) && (cur_size <= SIZE_W'(MAX_SLOTS)));

    a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        SIZE_W'(cur_ptr) < cur_size);

    a_r4_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> SIZE_W'(irq_slot) < cur_size);

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && !cfg_we) |=> (irq && $stable(irq_slot)));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cfg_we) |=> ovf);

endmodule

bind slot_busy_scanner slot_busy_scanner_chk #(
    .MAX_SLOTS (MAX_SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .tick     (tick),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .irq_slot (irq_slot),
    .ovf      (ovf),
    .cur_ptr  (cur_ptr),
    .cur_size (cur_size)
);

// File: tb/sim_slot_busy_scanner.sv
module sim_slot_busy_scanner;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAX_SLOTS  = 16;
    localparam int FIFO_DEPTH = 2;
    localparam int SLOT_W     = 4;
    localparam int SIZE_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic              tick = 1'b0;
    logic              set_en = 1'b0;
    logic [SLOT_W-1:0] set_slot = '0;
    logic              clr_en = 1'b0;
    logic [SLOT_W-1:0] clr_slot = '0;
    logic              irq_ack = 1'b0;
    logic              irq;
    logic [SLOT_W-1:0] irq_slot;
    logic              ovf;

    int checks = 0;
    int fails  = 0;

    always #2.5ns clk = ~clk;

    slot_busy_scanner #(
        .MAX_SLOTS  (MAX_SLOTS),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_size (cfg_size),
        .tick     (tick),
        .set_en   (set_en),
        .set_slot (set_slot),
        .clr_en   (clr_en),
        .clr_slot (clr_slot),
        .irq_ack  (irq_ack),
        .irq      (irq),
        .irq_slot (irq_slot),
        .ovf      (ovf)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_cfg(input int v);
        cfg_we = 1'b1; cfg_size = SIZE_W'(v);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_set(input int s);
        set_en = 1'b1; set_slot = SLOT_W'(s);
        step();
        set_en = 1'b0;
    endtask

    task automatic do_clr(input int s);
        clr_en = 1'b1; clr_slot = SLOT_W'(s);
        step();
        clr_en = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        tick = 1'b1;
        repeat (n) step();
        tick = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 ovf after reset", int'(ovf), 0);
        do_set(15);
        do_ticks(14);
        chk("R1 no irq before slot 15", int'(irq), 0);
        do_ticks(1);
        chk("R1 irq at slot 15", int'(irq), 1);
        chk("R1 slot 15", int'(irq_slot), 15);
        do_ack();
        chk("R5 irq drops after ack", int'(irq), 0);
        do_clr(15);
    endtask

    task automatic t_wrap();
        do_cfg(5);
        do_set(0);
        do_ticks(4);
        chk("R3 no irq on slots 1..4", int'(irq), 0);
        do_ticks(1);
        chk("R3 wrap reaches slot 0", int'(irq), 1);
        chk("R3 wrap slot", int'(irq_slot), 0);
        do_ack();
        do_clr(0);
    endtask

    task automatic t_cfg_bad();
        do_cfg(0);
        do_cfg(17);
        do_set(4);
        do_set(0);
        do_ticks(4);
        chk("R2 slot 4 reached", int'(irq_slot), 4);
        do_ack();
        do_ticks(1);
        chk("R2 size kept at 5 irq", int'(irq), 1);
        chk("R2 size kept at 5 slot", int'(irq_slot), 0);
        do_ack();
        do_clr(4);
        do_clr(0);
    endtask

    task automatic t_skip_hold();
        do_set(1);
        do_set(3);
        do_ticks(1);
        chk("R4 busy slot 1", int'(irq_slot), 1);
        repeat (3) step();
        chk("R5 irq held", int'(irq), 1);
        chk("R5 slot held", int'(irq_slot), 1);
        do_ack();
        do_ticks(1);
        chk("R4 idle slot 2 passed", int'(irq), 0);
        do_ticks(1);
        chk("R4 busy slot 3 irq", int'(irq), 1);
        chk("R4 busy slot 3", int'(irq_slot), 3);
        do_ack();
        do_clr(1);
        do_clr(3);
    endtask

    task automatic t_queue();
        do_cfg(5);
        for (int s = 1; s <= 4; s++) do_set(s);
        do_ticks(3);
        chk("R6 first slot shown", int'(irq_slot), 1);
        chk("R7 no overflow yet", int'(ovf), 0);
        do_ticks(1);
        chk("R7 overflow on full queue", int'(ovf), 1);
        do_ack();
        chk("R6 second slot", int'(irq_slot), 2);
        do_ack();
        chk("R6 third slot", int'(irq_slot), 3);
        do_ack();
        chk("R7 dropped slot not shown", int'(irq), 0);
        chk("R7 ovf sticky", int'(ovf), 1);
        do_cfg(5);
        chk("R2 cfg clears ovf", int'(ovf), 0);
        for (int s = 1; s <= 4; s++) do_clr(s);
    endtask

    task automatic t_setclr();
        set_en = 1'b1; set_slot = 4'd2;
        clr_en = 1'b1; clr_slot = 4'd2;
        step();
        set_en = 1'b0; clr_en = 1'b0;
        do_ticks(2);
        chk("R8 clear wins", int'(irq), 0);
        do_set(2);
        do_ticks(5);
        chk("R8 set visible", int'(irq), 1);
        chk("R8 set slot", int'(irq_slot), 2);
        do_ack();
        do_clr(2);
        do_ticks(5);
        chk("R8 clear visible", int'(irq), 0);
    endtask

    task automatic t_oob();
        do_cfg(8);
        do_set(5);
        do_cfg(4);
        do_set(6);
        do_clr(5);
        do_cfg(8);
        do_ticks(5);
        chk("R9 out-of-range clear ignored", int'(irq), 1);
        chk("R9 slot 5 kept", int'(irq_slot), 5);
        do_ack();
        do_ticks(1);
        chk("R9 out-of-range set ignored", int'(irq), 0);
        do_clr(5);
    endtask

    task automatic t_repeat();
        do_cfg(3);
        do_set(1);
        do_ticks(1);
        chk("R10 first lap", int'(irq_slot), 1);
        do_ack();
        do_ticks(2);
        chk("R10 quiet between laps", int'(irq), 0);
        do_ticks(1);
        chk("R10 second lap irq", int'(irq), 1);
        chk("R10 second lap slot", int'(irq_slot), 1);
        do_ack();
        do_clr(1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_wrap();
        t_cfg_bad();
        t_skip_hold();
        t_queue();
        t_setclr();
        t_oob();
        t_repeat();
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

endmodule